// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block translates a 48-bit virtual address into a physical address by walking a four-level radix tree of 64-bit translation entries held in memory. A caller presents the virtual address, the frame number of the root table, the access kind (read, write or instruction fetch), whether the access comes from user mode, and whether no-execute protection is on. The walker then reads one entry per level through a single memory port that allows only one request at a time. It stops early when an entry maps a 1 GiB or 2 MiB page.

As it descends, the walker checks each entry for presence and for reserved bits. It folds the write, user and no-execute rights of every level into one effective set of rights. It also writes back entries whose accessed flag is clear. At the leaf it sets the accessed flag, and on a permitted write it sets the dirty flag as well, using one write-back. The walk ends with a one-cycle done pulse. That pulse carries either the physical address, the page size and the effective rights, or a fault with its vector and error code.

Top module: `ptw_walker`

## Requirements
- R1: If bits 63:47 of the virtual address are not all equal, the walk ends with a fault, vector 13 and error code 0, and no memory request is made.
- R2: The entry address at each level is the table base (a 4 KiB-aligned frame) plus eight times a 9-bit index. The index comes from virtual address bits 47:39 at the root (level 3), then 38:30, 29:21, and 20:12 at level 0. Reads are issued in that order.
- R3: An entry with bit 0 clear ends the walk with a page fault, vector 14, and error-code bit 0 equal to 0.
- R4: Bit 7 (page size) set in a root entry is a reserved-bit fault. At level 2 it ends the walk with a 1 GiB page (done_size 2). At level 1 it ends the walk with a 2 MiB page (done_size 1). A level-0 leaf gives done_size 0.
- R5: Entry bits 62:PA_W are reserved, and bit 63 is also reserved when no-execute is off. A reserved-bit fault is vector 14 with error-code bits 3 and 0 both set.
- R6: In a large-page leaf, the address bits between bit 13 and the page-size boundary are reserved. Bit 12 is excluded from this check.
- R7: The effective write right (bit 1) and user right (bit 2) are the AND over all levels, and no-execute (bit 63) is the OR over all levels. A protection fault (vector 14, error bit 0 = 1) occurs in three cases: a user access to a page without the user right, a write to a page without the write right, or a fetch from a no-execute page while no-execute is on.
- R8: A non-leaf entry whose bit 5 (accessed) is clear is written back, at the address it was read from, with bit 5 set, before the next level is read.
- R9: A leaf that passes all checks is written back once, with bit 5 set and, for a write access, bit 6 (dirty) set. No write-back occurs if those bits already hold those values.
- R10: On success, the physical address is the leaf address with the bits below the page size cleared, ORed with the virtual-address bits below the page size.
- R11: In a page fault, error-code bit 1 is 1 for a write, bit 2 is 1 for a user access, and bit 4 is 1 for a fetch while no-execute is on.
- R12: The memory port has at most one read outstanding. A request stays valid with a stable address until it is accepted. A write completes on acceptance and gets no response.
- R13: After reset, req_ready is 1 and both done_valid and mem_req_valid are 0. req_ready is 1 only while the walker is idle. done_valid is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 64 | Virtual address to translate |
| req_root | input | PA_W-12 | Frame number of the root table |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_user | input | 1 | Access comes from user mode |
| req_nxe | input | 1 | No-execute protection enabled |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 for an entry write-back, 0 for a read |
| mem_req_addr | output | PA_W | Byte address of the entry |
| mem_req_wdata | output | 64 | Entry value to write back |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 64 | Read data |
| done_valid | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Walk ended in a fault |
| done_vec | output | 8 | Fault vector (13 or 14) |
| done_err | output | 5 | Page-fault error code |
| done_paddr | output | PA_W | Translated physical address |
| done_size | output | 2 | Page size: 0 4 KiB, 1 2 MiB, 2 1 GiB |
| done_writable | output | 1 | Effective write right |
| done_user | output | 1 | Effective user right |
| done_nx | output | 1 | Effective no-execute |

## Verification
The bench builds the walker with its default PA_W of 52. Entry bits 62:52 are therefore live reserved bits that random entries can hit. Leaf frame numbers use the full 40-bit width, so the address-merge check covers high physical bits and not only the page offset. Tables are placed at randomized distinct frames. A wrongly computed entry address therefore reads an empty slot, and the resulting not-present fault shows up as a mismatch.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD      = 3'd1,
        ST_WAIT    = 3'd2,
        ST_WB_UP   = 3'd3,
        ST_WB_LEAF = 3'd4
    } st_e;

    localparam logic [1:0] ACC_READ  = 2'd0;
    localparam logic [1:0] ACC_WRITE = 2'd1;
    localparam logic [1:0] ACC_FETCH = 2'd2;

    localparam int B_PRES = 0;
    localparam int B_WR   = 1;
    localparam int B_USR  = 2;
    localparam int B_ACC  = 5;
    localparam int B_DIRT = 6;
    localparam int B_BIG  = 7;
    localparam int B_NOX  = 63;

    localparam logic [7:0] VEC_GP = 8'd13;
    localparam logic [7:0] VEC_PF = 8'd14;
endpackage

// File: rtl/ptw_index_addr.sv
module ptw_index_addr #(
    parameter int PA_W = 52
) (
    input  logic [PA_W-13:0] bfn,
    input  logic [35:0]      vpn,
    input  logic [1:0]       lvl,
    output logic [PA_W-1:0]  eaddr
);
    localparam int LEVELS = 4;
    localparam int IDX_W  = 9;

    logic [IDX_W-1:0] slice [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_slice
        assign slice[g] = vpn[IDX_W*g +: IDX_W];
    end

    assign eaddr = {bfn, slice[lvl], 3'b000};
endmodule

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
    import ptw_pkg::*;
#(
    parameter int PA_W = 52
) (
    input  logic [63:0]     ent,
    input  logic [1:0]      lvl,
    input  logic            nxe,
    input  logic [1:0]      acc,
    input  logic            usr,
    input  logic            rw_in,
    input  logic            us_in,
    input  logic            nx_in,
    input  logic [29:0]     va_off,
    output logic            present,
    output logic            rsvd,
    output logic            leaf,
    output logic            rw_out,
    output logic            us_out,
    output logic            nx_out,
    output logic            prot_fail,
    output logic            acc_clear,
    output logic            leaf_upd,
    output logic [63:0]     up_wdata,
    output logic [63:0]     leaf_wdata,
    output logic [PA_W-13:0] next_bfn,
    output logic [PA_W-1:0] pa,
    output logic [1:0]      size
);
    localparam logic [63:0] HI_MASK = {1'b0, {(63-PA_W){1'b1}}, {PA_W{1'b0}}};

    logic           big_1g, big_2m, junk;
    logic [PA_W-1:0] lowmask;

    always_comb begin
        present  = ent[B_PRES];
        big_1g   = (lvl == 2'd2) && ent[B_BIG];
        big_2m   = (lvl == 2'd1) && ent[B_BIG];
        junk     = (big_1g && (|ent[29:13])) || (big_2m && (|ent[20:13]));
        rsvd     = (|(ent & HI_MASK)) || (!nxe && ent[B_NOX])
                   || ((lvl == 2'd3) && ent[B_BIG]) || junk;
        leaf     = (lvl == 2'd0) || big_1g || big_2m;
        rw_out   = rw_in & ent[B_WR];
        us_out   = us_in & ent[B_USR];
        nx_out   = nx_in | ent[B_NOX];
        prot_fail = (usr && !us_out) || ((acc == ACC_WRITE) && !rw_out)
                    || ((acc == ACC_FETCH) && nxe && nx_out);
        acc_clear = !ent[B_ACC];
        up_wdata  = ent | (64'd1 << B_ACC);
        leaf_wdata = up_wdata | ((acc == ACC_WRITE) ? (64'd1 << B_DIRT) : 64'd0);
        leaf_upd  = (leaf_wdata != ent);
        next_bfn  = ent[PA_W-1:12];
        size      = big_1g ? 2'd2 : (big_2m ? 2'd1 : 2'd0);
        case (size)
            2'd2:    lowmask = PA_W'(30'h3fff_ffff);
            2'd1:    lowmask = PA_W'(21'h1f_ffff);
            default: lowmask = PA_W'(12'hfff);
        endcase
        pa = (ent[PA_W-1:0] & ~lowmask) | (PA_W'(va_off) & lowmask);
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int PA_W = 52
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [63:0]       req_vaddr,
    input  logic [PA_W-13:0]  req_root,
    input  logic [1:0]        req_acc,
    input  logic              req_user,
    input  logic              req_nxe,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [PA_W-1:0]   mem_req_addr,
    output logic [63:0]       mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_rdata,
    output logic              done_valid,
    output logic              done_fault,
    output logic [7:0]        done_vec,
    output logic [4:0]        done_err,
    output logic [PA_W-1:0]   done_paddr,
    output logic [1:0]        done_size,
    output logic              done_writable,
    output logic              done_user,
    output logic              done_nx
);
    typedef struct packed {
        st_e              st;
        logic [1:0]       lvl;
        logic [47:0]      va;
        logic [1:0]       acc;
        logic             usr;
        logic             nxe;
        logic [PA_W-13:0] bfn;
        logic [PA_W-1:0]  eaddr;
        logic [63:0]      ent;
        logic             rw;
        logic             us;
        logic             nx;
        logic             done;
        logic             flt;
        logic [7:0]       vec;
        logic [4:0]       err;
        logic [PA_W-1:0]  pa;
        logic [1:0]       size;
    } walk_t;

    walk_t q, d;

    logic [PA_W-1:0]  idx_addr;
    logic             e_present, e_rsvd, e_leaf, e_rw, e_us, e_nx;
    logic             e_prot, e_acc_clear, e_leaf_upd;
    logic [63:0]      e_up_wdata, e_leaf_wdata;
    logic [PA_W-13:0] e_next_bfn;
    logic [PA_W-1:0]  e_pa;
    logic [1:0]       e_size;
    logic             canon, ibit, wbit;

    ptw_index_addr #(.PA_W(PA_W)) u_idx (
        .bfn   (q.bfn),
        .vpn   (q.va[47:12]),
        .lvl   (q.lvl),
        .eaddr (idx_addr)
    );

    ptw_entry_eval #(.PA_W(PA_W)) u_eval (
        .ent        (mem_rsp_rdata),
        .lvl        (q.lvl),
        .nxe        (q.nxe),
        .acc        (q.acc),
        .usr        (q.usr),
        .rw_in      (q.rw),
        .us_in      (q.us),
        .nx_in      (q.nx),
        .va_off     (q.va[29:0]),
        .present    (e_present),
        .rsvd       (e_rsvd),
        .leaf       (e_leaf),
        .rw_out     (e_rw),
        .us_out     (e_us),
        .nx_out     (e_nx),
        .prot_fail  (e_prot),
        .acc_clear  (e_acc_clear),
        .leaf_upd   (e_leaf_upd),
        .up_wdata   (e_up_wdata),
        .leaf_wdata (e_leaf_wdata),
        .next_bfn   (e_next_bfn),
        .pa         (e_pa),
        .size       (e_size)
    );

    assign canon = (&req_vaddr[63:47]) || !(|req_vaddr[63:47]);
    assign ibit  = (q.acc == ACC_FETCH) && q.nxe;
    assign wbit  = (q.acc == ACC_WRITE);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.va  = req_vaddr[47:0];
                    d.acc = req_acc;
                    d.usr = req_user;
                    d.nxe = req_nxe;
                    d.bfn = req_root;
                    d.lvl = 2'd3;
                    d.rw  = 1'b1;
                    d.us  = 1'b1;
                    d.nx  = 1'b0;
                    if (!canon) begin
                        d.done = 1'b1;
                        d.flt  = 1'b1;
                        d.vec  = VEC_GP;
                        d.err  = 5'd0;
                    end else begin
                        d.st = ST_RD;
                    end
                end
            end
            ST_RD: begin
                if (mem_req_ready) begin
                    d.eaddr = idx_addr;
                    d.st    = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    d.ent = mem_rsp_rdata;
                    d.rw  = e_rw;
                    d.us  = e_us;
                    d.nx  = e_nx;
                    if (!e_present || e_rsvd || (e_leaf && e_prot)) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        d.flt  = 1'b1;
                        d.vec  = VEC_PF;
                        d.err  = {ibit, e_present && e_rsvd, q.usr, wbit, e_present};
                    end else if (!e_leaf) begin
                        if (e_acc_clear) begin
                            d.ent = e_up_wdata;
                            d.st  = ST_WB_UP;
                        end else begin
                            d.bfn = e_next_bfn;
                            d.lvl = q.lvl - 2'd1;
                            d.st  = ST_RD;
                        end
                    end else begin
                        d.pa   = e_pa;
                        d.size = e_size;
                        if (e_leaf_upd) begin
                            d.ent = e_leaf_wdata;
                            d.st  = ST_WB_LEAF;
                        end else begin
                            d.st   = ST_IDLE;
                            d.done = 1'b1;
                            d.flt  = 1'b0;
                            d.vec  = 8'd0;
                            d.err  = 5'd0;
                        end
                    end
                end
            end
            ST_WB_UP: begin
                if (mem_req_ready) begin
                    d.bfn = q.ent[PA_W-1:12];
                    d.lvl = q.lvl - 2'd1;
                    d.st  = ST_RD;
                end
            end
            ST_WB_LEAF: begin
                if (mem_req_ready) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    d.flt  = 1'b0;
                    d.vec  = 8'd0;
                    d.err  = 5'd0;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready     = (q.st == ST_IDLE);
    assign mem_req_valid = (q.st == ST_RD) || (q.st == ST_WB_UP) || (q.st == ST_WB_LEAF);
    assign mem_req_we    = (q.st == ST_WB_UP) || (q.st == ST_WB_LEAF);
    assign mem_req_addr  = (q.st == ST_RD) ? idx_addr : q.eaddr;
    assign mem_req_wdata = q.ent;
    assign done_valid    = q.done;
    assign done_fault    = q.flt;
    assign done_vec      = q.vec;
    assign done_err      = q.err;
    assign done_paddr    = q.pa;
    assign done_size     = q.size;
    assign done_writable = q.rw;
    assign done_user     = q.us;
    assign done_nx       = q.nx;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int PA_W = 52
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic            mem_req_we,
    input logic [PA_W-1:0] mem_req_addr,
    input logic            mem_rsp_valid,
    input logic            done_valid,
    input logic            done_fault,
    input logic [7:0]      done_vec,
    input logic [4:0]      done_err
);
    logic [PA_W-1:0] last_rd_q;
    logic            outst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_rd_q <= '0;
            outst_q   <= 1'b0;
        end else if (mem_req_valid && mem_req_ready && !mem_req_we) begin
            last_rd_q <= mem_req_addr;
            outst_q   <= 1'b1;
        end else if (mem_rsp_valid) begin
            outst_q   <= 1'b0;
        end
    end

    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));

    p_one_outst_r12: assert property (@(posedge clk) disable iff (!rst_n)
        outst_q |-> !(mem_req_valid && !mem_req_we));

    p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid);

    p_done_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> req_ready);

    p_gp_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && done_vec == 8'd13 |-> done_fault && done_err == 5'd0);

    p_rsvd_present_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && done_fault && done_err[3] |-> done_err[0]);

    p_wb_same_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_we |-> mem_req_addr == last_rd_q);
endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W)) u_ptw_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .done_valid    (done_valid),
    .done_fault    (done_fault),
    .done_vec      (done_vec),
    .done_err      (done_err)
);

// File: tb/test_ptw_walker.sv
module test_ptw_walker;
    localparam int PA_W = 52;
    localparam logic [63:0] F_P  = 64'h1;
    localparam logic [63:0] F_W  = 64'h2;
    localparam logic [63:0] F_U  = 64'h4;
    localparam logic [63:0] F_A  = 64'h20;
    localparam logic [63:0] F_D  = 64'h40;
    localparam logic [63:0] F_PS = 64'h80;
    localparam logic [63:0] F_NX = 64'h8000_0000_0000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [63:0] req_vaddr = '0;
    logic [PA_W-13:0] req_root = '0;
    logic [1:0] req_acc = '0;
    logic req_user = 1'b0;
    logic req_nxe = 1'b0;
    logic mem_req_valid, mem_req_we;
    logic mem_req_ready = 1'b0;
    logic [PA_W-1:0] mem_req_addr;
    logic [63:0] mem_req_wdata;
    logic mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_rdata = '0;
    logic done_valid, done_fault, done_writable, done_user, done_nx;
    logic [7:0] done_vec;
    logic [4:0] done_err;
    logic [PA_W-1:0] done_paddr;
    logic [1:0] done_size;

    always #4 clk = ~clk;

    ptw_walker #(.PA_W(PA_W)) i_ptw_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_root(req_root), .req_acc(req_acc),
        .req_user(req_user), .req_nxe(req_nxe),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .done_valid(done_valid),
        .done_fault(done_fault), .done_vec(done_vec), .done_err(done_err),
        .done_paddr(done_paddr), .done_size(done_size),
        .done_writable(done_writable), .done_user(done_user), .done_nx(done_nx)
    );

    logic [63:0] mem [logic [63:0]];
    int n_chk = 0;
    int n_bad = 0;

    // memory model: responses one cycle after a read is accepted
    logic pend = 1'b0;
    logic [63:0] pend_data = '0;
    int rd_n = 0;
    int wr_n = 0;
    logic ovl = 1'b0;
    logic [63:0] rd_log [8];

    always @(negedge clk) begin
        if (pend) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_rdata = pend_data;
            pend = 1'b0;
        end else begin
            mem_rsp_valid = 1'b0;
            mem_rsp_rdata = {$urandom, $urandom};
        end
        mem_req_ready = ($urandom % 10) < 7;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            if (mem_req_we) begin
                mem[64'(mem_req_addr)] = mem_req_wdata;
                wr_n++;
            end else begin
                if (pend) ovl = 1'b1;
                rd_log[rd_n % 8] = 64'(mem_req_addr);
                rd_n++;
                pend = 1'b1;
                pend_data = mem.exists(64'(mem_req_addr)) ? mem[64'(mem_req_addr)] : 64'h0;
            end
        end
    end

    typedef struct {
        logic        flt;
        logic [7:0]  vec;
        logic [4:0]  err;
        logic [63:0] pa;
        logic [1:0]  size;
        logic        wr, us, nx;
        int          nrd, nwr;
        logic [63:0] ra [4];
        logic [63:0] wa [4];
        logic [63:0] wv [4];
        string       wt [4];
        string       tag;
    } exp_t;

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic void ref_walk(input logic [63:0] va, input logic [PA_W-13:0] rfn,
                                     input logic [1:0] acc, input logic usr, input logic nxe,
                                     output exp_t x);
        logic [63:0] base, a, e, nv, mask;
        logic rw, us, nx, ib, wb, leaf, rsv, junk, prot;
        int sh;
        x.flt = 0; x.vec = 0; x.err = 0; x.pa = 0; x.size = 0;
        x.wr = 0; x.us = 0; x.nx = 0; x.nrd = 0; x.nwr = 0; x.tag = "R10";
        for (int i = 0; i < 4; i++) begin
            x.ra[i] = 0; x.wa[i] = 0; x.wv[i] = 0; x.wt[i] = "R8";
        end
        ib = (acc == 2'd2) && nxe;
        wb = (acc == 2'd1);
        if (!((&va[63:47]) || !(|va[63:47]))) begin
            x.flt = 1; x.vec = 13; x.err = 0; x.tag = "R1";
            return;
        end
        base = 64'(rfn) << 12;
        rw = 1; us = 1; nx = 0;
        for (int l = 3; l >= 0; l--) begin
            a = base + 64'(va[12+9*l +: 9]) * 8;
            e = mem.exists(a) ? mem[a] : 64'h0;
            x.ra[x.nrd] = a; x.nrd++;
            x.wr = rw & e[1]; x.us = us & e[2]; x.nx = nx | e[63];
            if (!e[0]) begin
                x.flt = 1; x.vec = 14; x.err = {ib, 1'b0, usr, wb, 1'b0}; x.tag = "R3";
                return;
            end
            junk = (l == 2 && e[7] && (|e[29:13])) || (l == 1 && e[7] && (|e[20:13]));
            rsv = (|e[62:PA_W]) || (!nxe && e[63]) || (l == 3 && e[7]) || junk;
            if (rsv) begin
                x.flt = 1; x.vec = 14; x.err = {ib, 1'b1, usr, wb, 1'b1};
                x.tag = junk ? "R6" : ((l == 3 && e[7]) ? "R4" : "R5");
                return;
            end
            rw = x.wr; us = x.us; nx = x.nx;
            leaf = (l == 0) || (l < 3 && e[7]);
            if (!leaf) begin
                if (!e[5]) begin
                    x.wa[x.nwr] = a; x.wv[x.nwr] = e | F_A; x.wt[x.nwr] = "R8"; x.nwr++;
                end
                base = {12'h0, e[PA_W-1:12], 12'h0};
                continue;
            end
            prot = (usr && !us) || (wb && !rw) || (acc == 2'd2 && nxe && nx);
            if (prot) begin
                x.flt = 1; x.vec = 14; x.err = {ib, 1'b0, usr, wb, 1'b1}; x.tag = "R7";
                return;
            end
            sh = (l == 0) ? 12 : ((l == 1) ? 21 : 30);
            mask = (64'h1 << sh) - 1;
            x.pa = (64'(e[PA_W-1:0]) & ~mask) | (va & mask);
            x.size = (l == 2) ? 2'd2 : ((l == 1) ? 2'd1 : 2'd0);
            nv = e | F_A | (wb ? F_D : 64'h0);
            if (nv != e) begin
                x.wa[x.nwr] = a; x.wv[x.nwr] = nv; x.wt[x.nwr] = "R9"; x.nwr++;
            end
            return;
        end
    endfunction

    // build tables for one walk; non-leaf entries get a pointer to a fresh table
    task automatic mk(input logic [63:0] va, input logic [PA_W-13:0] rfn, input logic [63:0] e [4]);
        logic [63:0] base, a, ent, tb;
        logic leaf;
        mem.delete();
        base = 64'(rfn) << 12;
        for (int l = 3; l >= 0; l--) begin
            a = base + 64'(va[12+9*l +: 9]) * 8;
            tb = (64'h100 + 64'(l) * 64'h40 + 64'($urandom % 64)) << 12;
            ent = e[l];
            leaf = (l == 0) || (l < 3 && ent[7]);
            if (!leaf) ent = ent | tb;
            mem[a] = ent;
            if (leaf || !ent[0]) break;
            base = tb;
        end
    endtask

    task automatic run(input logic [63:0] va, input logic [PA_W-13:0] rfn,
                       input logic [1:0] acc, input logic usr, input logic nxe);
        exp_t x;
        int t;
        ref_walk(va, rfn, acc, usr, nxe, x);
        @(negedge clk);
        rd_n = 0; wr_n = 0; ovl = 1'b0;
        req_valid = 1'b1; req_vaddr = va; req_root = rfn;
        req_acc = acc; req_user = usr; req_nxe = nxe;
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (!done_valid && t < 400) begin
            @(negedge clk);
            t++;
        end
        if (!done_valid) begin
            chk(1'b0, "R13", "walk timeout", 64'(t), 64'd0);
            rst_n = 1'b0;
            @(negedge clk);
            rst_n = 1'b1;
            return;
        end
        chk(done_fault == x.flt, x.tag, "fault flag", 64'(done_fault), 64'(x.flt));
        chk(done_vec == x.vec, x.tag, "vector", 64'(done_vec), 64'(x.vec));
        if (x.flt) begin
            chk(done_err == x.err, "R11", "error code", 64'(done_err), 64'(x.err));
        end else begin
            chk(64'(done_paddr) == x.pa, "R10", "paddr", 64'(done_paddr), x.pa);
            chk(done_size == x.size, "R4", "page size", 64'(done_size), 64'(x.size));
            chk({done_writable, done_user, done_nx} == {x.wr, x.us, x.nx}, "R7", "rights",
                64'({done_writable, done_user, done_nx}), 64'({x.wr, x.us, x.nx}));
        end
        if (x.tag == "R1")
            chk(rd_n + wr_n == 0, "R1", "memory accesses", 64'(rd_n + wr_n), 64'd0);
        chk(rd_n == x.nrd, "R2", "read count", 64'(rd_n), 64'(x.nrd));
        for (int i = 0; i < 4; i++)
            if (i < x.nrd && i < rd_n)
                chk(rd_log[i] == x.ra[i], "R2", "entry address", rd_log[i], x.ra[i]);
        chk(wr_n == x.nwr, "R8 R9", "write-back count", 64'(wr_n), 64'(x.nwr));
        for (int i = 0; i < 4; i++)
            if (i < x.nwr)
                chk(mem[x.wa[i]] == x.wv[i], x.wt[i], "written entry", mem[x.wa[i]], x.wv[i]);
        chk(!ovl, "R12", "second read while one outstanding", 64'(ovl), 64'd0);
        @(negedge clk);
        chk(!done_valid, "R13", "done pulse width", 64'(done_valid), 64'd0);
    endtask

    function automatic logic [63:0] rnd_ent(input int l);
        logic [63:0] e;
        logic leaf;
        e = 0;
        if ($urandom % 100 < 93) e |= F_P;
        if ($urandom % 100 < 85) e |= F_W;
        if ($urandom % 100 < 85) e |= F_U;
        if ($urandom % 2) e |= F_A;
        if ($urandom % 2) e |= F_D;
        if ($urandom % 100 < 12) e |= F_NX;
        if ($urandom % 100 < 3) e |= 64'h1 << 55;
        if (l == 3 && $urandom % 100 < 4) e |= F_PS;
        if ((l == 2 || l == 1) && $urandom % 100 < 25) e |= F_PS;
        leaf = (l == 0) || (l < 3 && e[7]);
        if (leaf) begin
            e |= ({$urandom, $urandom} & 64'h000F_FFFF_FFFF_F000);
            if (l == 2) e &= ~64'h3FFF_E000;
            if (l == 1) e &= ~64'h1F_E000;
            if (l > 0 && $urandom % 100 < 20) e |= 64'h1 << (13 + $urandom % ((l == 2) ? 17 : 8));
        end
        return e;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R13 global watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] e [4];
        logic [63:0] va;
        process::self().srandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R13", "reset req_ready", 64'(req_ready), 64'd1);
        chk(done_valid == 1'b0, "R13", "reset done_valid", 64'(done_valid), 64'd0);
        chk(mem_req_valid == 1'b0, "R13", "reset mem_req_valid", 64'(mem_req_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: non-canonical
        run(64'h0000_8000_0000_0000, 40'h3, 2'd0, 1'b0, 1'b1);
        // R8 R9: high-half 4 KiB write with accessed bits clear everywhere
        e[3] = F_P | F_W | F_U; e[2] = F_P | F_W | F_U; e[1] = F_P | F_W | F_U;
        e[0] = F_P | F_W | F_U | 64'hABCDE000;
        va = 64'hFFFF_8000_1234_5678;
        mk(va, 40'h5, e); run(va, 40'h5, 2'd1, 1'b1, 1'b1);
        // R4: page-size bit at the root is reserved
        e[3] = F_P | F_W | F_U | F_A | F_PS;
        mk(va, 40'h5, e); run(va, 40'h5, 2'd0, 1'b0, 1'b1);
        // R4: 1 GiB page
        va = 64'h0000_1234_5678_9ABC;
        e[3] = F_P | F_W | F_U | F_A; e[2] = F_P | F_W | F_U | F_A | F_D | F_PS | (64'h5 << 30);
        mk(va, 40'h7, e); run(va, 40'h7, 2'd0, 1'b0, 1'b1);
        // R6: 2 MiB with bit 13 set; then with only bit 12 set
        e[2] = F_P | F_W | F_U | F_A; e[1] = F_P | F_W | F_U | F_A | F_D | F_PS | 64'h7_E000_2000;
        mk(va, 40'h7, e); run(va, 40'h7, 2'd0, 1'b0, 1'b1);
        e[1] = F_P | F_W | F_U | F_A | F_D | F_PS | 64'h7_E000_1000;
        mk(va, 40'h7, e); run(va, 40'h7, 2'd1, 1'b0, 1'b1);
        // R5: bit 63 reserved when no-execute is off
        e[1] = F_P | F_W | F_U | F_A | F_NX; e[0] = F_P | F_W | F_U | F_A | 64'h9000;
        mk(va, 40'h7, e); run(va, 40'h7, 2'd0, 1'b0, 1'b0);
        // R7 R11: fetch from no-execute page
        mk(va, 40'h7, e); run(va, 40'h7, 2'd2, 1'b0, 1'b1);
        // R7 R11: user access to supervisor page
        e[1] = F_P | F_W | F_A; e[0] = F_P | F_W | F_U | F_A | 64'h9000;
        mk(va, 40'h7, e); run(va, 40'h7, 2'd0, 1'b1, 1'b1);
        // R9: read with accessed and dirty already set
        e[1] = F_P | F_W | F_U | F_A; e[0] = F_P | F_W | F_U | F_A | F_D | 64'h9000;
        mk(va, 40'h7, e); run(va, 40'h7, 2'd0, 1'b1, 1'b1);

        for (int n = 0; n < 400; n++) begin
            logic [PA_W-13:0] rfn;
            va = {$urandom, $urandom};
            va[63:48] = {16{va[47]}};
            if ($urandom % 100 < 5) va[55] = ~va[55];
            rfn = PA_W'(1 + $urandom % 200);
            for (int l = 0; l < 4; l++) e[l] = rnd_ent(l);
            mk(va, rfn, e);
            run(va, rfn, 2'($urandom % 3), 1'($urandom % 2), ($urandom % 10) < 7);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule